// File: doc/BRIEF.md
# Tiled Framebuffer Scan-Out Address Generator

This block turns a table of tile pointers in memory into the ordered list of memory reads that a scan-out engine needs to paint a tiled framebuffer onto a raster of fixed resolution. Software programs two registers, one for colour depth and one for frame settings, then pulses a frame-start input. The block fetches one 16-bit tile descriptor at a time and converts it into a 64 KB tile base. It then issues burst read requests that cover the visible part of that tile. Each request carries the raster byte offset where its data belongs.

Two walk styles are offered. In tiled mode every tile is 512 bytes wide and 128 lines tall, and one read is issued per tile line. Tiles that sit on the right or bottom edge of the screen are clipped. In linear mode each tile is read as one contiguous 64 KB block, cut into fixed-size chunks, until the whole frame has been requested. The memory port uses a request/grant handshake with one request in flight. Descriptor data comes back on a separate valid strobe.

Top module: `tile_scan_agen`

## Requirements
- R1: After reset `busy` and `memReq` are low, and they stay low until a frame is started.
- R2: A `frameStart` pulse starts a walk only if frame-control bit 0 (DMA enable) is 1 and bits 31..9 (tile table base) are nonzero. Otherwise no request is issued and `busy` stays low.
- R3: Tile n's descriptor is read with `memIsDesc`=1, address = table base + 2*n, length 2 and raster offset 0. The tile counter n restarts at 0 every frame. The returned 16-bit value shifted left by 16 is the tile's base address.
- R4: Plane-control bits 14..13 hold a depth code d. A pixel takes 2^d bytes, and a tile line holds 512>>d pixels.
- R5: In tiled mode, line y of a tile at (xb, yb) is read at tile base + 512*y. Its length is the visible pixel count times 2^d, and its raster offset is ((yb+y)*XRES + xb)*2^d.
- R6: Tiles are taken left to right in columns 512>>d pixels wide, and each row of tiles is 128 lines tall. The right-most column is clipped to XRES and the bottom row to YRES. The walk ends after the last line of the bottom-right tile.
- R7: In linear mode (frame-control bit 1 = 1), each tile is requested as CHUNK_BYTES-sized chunks at tile base + k*CHUNK_BYTES, with raster offsets that run on without gaps. After 64 KB the next descriptor is fetched. The final chunk is clipped so that XRES*YRES*2^d bytes are requested in total.
- R8: Only one request is outstanding at a time. While `memReq` is high and not granted, address, length, raster offset and `memIsDesc` do not change.
- R9: `busy` is high from the cycle after an accepted `frameStart` until the final request's grant, and it is low in the cycle after that grant.
- R10: A `frameStart` during a walk abandons it and restarts the frame from tile 0.
- R11: The mode, depth and table base are captured at `frameStart`. Register writes (`regWrSel` 0 = plane control, 1 = frame control) that land during a walk only affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | 0 selects plane control, 1 selects frame control |
| regWrData | input | 32 | Register write data |
| frameStart | input | 1 | One-cycle pulse that starts or restarts a frame |
| memReq | output | 1 | Read request valid |
| memIsDesc | output | 1 | Request is a tile descriptor fetch |
| memAddr | output | ADDR_W | Request byte address |
| memLen | output | LEN_W | Request length in bytes |
| memDstOff | output | 32 | Raster byte offset of the request data |
| memGnt | input | 1 | Request accepted in this cycle |
| memRdValid | input | 1 | Descriptor read data valid |
| memRdData | input | 16 | Descriptor read data |
| busy | output | 1 | A frame walk is in progress |

## Verification
A request is visible in the cycle after the state change that produces it, and it moves on in the first cycle after its grant. For a descriptor, the first line request is presented in the cycle after `memRdValid`. The bench's memory model samples and grants on the falling edge. It stalls each request for zero to two cycles, records every granted request, and compares the list against a model built from the requirements. `busy` is checked one cycle after the start pulse and again at exactly one cycle after the last grant.

// File: rtl/tile_scan_pkg.sv
package tile_scan_pkg;

  localparam int TILE_ROW_BYTES = 512;
  localparam int TILE_LINES     = 128;
  localparam int TILE_SPAN      = 65536;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DESC_REQ,
    ST_DESC_WAIT,
    ST_LINE_REQ
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // capture config, clear walk counters
    logic capDesc;  // latch descriptor into tile base
    logic advance;  // current line/chunk granted
    logic reqDesc;  // level: present descriptor request fields
  } ctlStrobe_t;

endpackage

// File: rtl/tile_scan_regs.sv
module tile_scan_regs (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  output logic [1:0]  depthCode,
  output logic        linearMode,
  output logic [22:0] tableBits,
  output logic        startOk
);
  logic dmaOn;
  logic unusedBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthCode  <= '0;
      linearMode <= 1'b0;
      dmaOn      <= 1'b0;
      tableBits  <= '0;
    end else if (wrEn) begin
      if (!wrSel) begin
        depthCode <= wrData[14:13];
      end else begin
        tableBits  <= wrData[31:9];
        linearMode <= wrData[1];
        dmaOn      <= wrData[0];
      end
    end
  end

  assign startOk    = dmaOn && (tableBits != '0);
  assign unusedBits = ^{wrData[12:0], wrData[31:15], wrData[8:2]};
endmodule

// File: rtl/tile_scan_ctrl.sv
module tile_scan_ctrl
  import tile_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       startOk,
  input  logic       memGnt,
  input  logic       memRdValid,
  input  logic       tileDone,
  input  logic       frameDone,
  output ctlStrobe_t strb,
  output logic       memReq,
  output logic       memIsDesc,
  output logic       busy
);
  scanState_t state, stateNxt;

  always_comb begin
    stateNxt     = state;
    strb         = '0;
    strb.reqDesc = (state == ST_DESC_REQ);
    if (frameStart) begin
      strb.start = startOk;
      stateNxt   = startOk ? ST_DESC_REQ : ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateNxt = ST_IDLE;
        ST_DESC_REQ: if (memGnt) stateNxt = ST_DESC_WAIT;
        ST_DESC_WAIT: if (memRdValid) begin
          strb.capDesc = 1'b1;
          stateNxt     = ST_LINE_REQ;
        end
        ST_LINE_REQ: if (memGnt) begin
          strb.advance = 1'b1;
          if (frameDone)     stateNxt = ST_IDLE;
          else if (tileDone) stateNxt = ST_DESC_REQ;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign memReq    = (state == ST_DESC_REQ) || (state == ST_LINE_REQ);
  assign memIsDesc = (state == ST_DESC_REQ);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/tile_scan_datapath.sv
module tile_scan_datapath
  import tile_scan_pkg::*;
#(
  parameter int XRES        = 640,
  parameter int YRES        = 480,
  parameter int CHUNK_BYTES = 16384,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [1:0]        cfgDepth,
  input  logic              cfgLinear,
  input  logic [22:0]       cfgTable,
  input  logic [15:0]       rdData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic [31:0]       reqDst,
  output logic              tileDone,
  output logic              frameDone
);
  localparam int MAXDIM    = (XRES > YRES) ? XRES : YRES;
  localparam int CW        = $clog2(MAXDIM + TILE_ROW_BYTES) + 1;
  localparam int FRAME_PIX = XRES * YRES;

  logic [1:0]        depthQ;
  logic              linQ;
  logic [ADDR_W-1:0] tblQ;
  logic [15:0]       tileNr;
  logic [ADDR_W-1:0] tileBase;
  logic [CW-1:0]     xBase, yBase;
  logic [6:0]        lineIdx;
  logic [16:0]       chunkOff;
  logic [31:0]       written;

  logic [31:0] tileW, remX, pix, remY, lines, frameBytes, remBytes, linLen;
  logic [31:0] tileLen, tileDst, lineOff;
  logic        lastLine, lastCol, lastRow, linTileEnd;

  always_comb begin
    tileW      = 32'(TILE_ROW_BYTES) >> depthQ;
    remX       = 32'(XRES) - 32'(xBase);
    pix        = (tileW < remX) ? tileW : remX;
    remY       = 32'(YRES) - 32'(yBase);
    lines      = (remY < 32'(TILE_LINES)) ? remY : 32'(TILE_LINES);
    lastLine   = (32'(lineIdx) == lines - 32'd1);
    lastCol    = (32'(xBase) + tileW) >= 32'(XRES);
    lastRow    = (32'(yBase) + 32'(TILE_LINES)) >= 32'(YRES);
    frameBytes = 32'(FRAME_PIX) << depthQ;
    remBytes   = frameBytes - written;
    linLen     = (remBytes < 32'(CHUNK_BYTES)) ? remBytes : 32'(CHUNK_BYTES);
    linTileEnd = (32'(chunkOff) + 32'(CHUNK_BYTES)) >= 32'(TILE_SPAN);
    tileLen    = pix << depthQ;
    tileDst    = (((32'(yBase) + 32'(lineIdx)) * 32'(XRES)) + 32'(xBase)) << depthQ;
    lineOff    = linQ ? 32'(chunkOff) : 32'({lineIdx, 9'b0});

    tileDone  = linQ ? linTileEnd : lastLine;
    frameDone = linQ ? (remBytes <= 32'(CHUNK_BYTES))
                     : (lastLine && lastCol && lastRow);

    if (strb.reqDesc) begin
      reqAddr = tblQ + ADDR_W'({tileNr, 1'b0});
      reqLen  = LEN_W'(2);
      reqDst  = '0;
    end else begin
      reqAddr = tileBase + ADDR_W'(lineOff);
      reqLen  = linQ ? LEN_W'(linLen) : LEN_W'(tileLen);
      reqDst  = linQ ? written : tileDst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthQ   <= '0;
      linQ     <= 1'b0;
      tblQ     <= '0;
      tileNr   <= '0;
      tileBase <= '0;
      xBase    <= '0;
      yBase    <= '0;
      lineIdx  <= '0;
      chunkOff <= '0;
      written  <= '0;
    end else if (strb.start) begin
      depthQ   <= cfgDepth;
      linQ     <= cfgLinear;
      tblQ     <= ADDR_W'({cfgTable, 9'b0});
      tileNr   <= '0;
      xBase    <= '0;
      yBase    <= '0;
      lineIdx  <= '0;
      chunkOff <= '0;
      written  <= '0;
    end else begin
      if (strb.capDesc) tileBase <= ADDR_W'({rdData, 16'b0});
      if (strb.advance) begin
        if (linQ) begin
          written <= written + linLen;
          if (linTileEnd) begin
            chunkOff <= '0;
            tileNr   <= tileNr + 16'd1;
          end else begin
            chunkOff <= chunkOff + 17'(CHUNK_BYTES);
          end
        end else if (lastLine) begin
          lineIdx <= '0;
          tileNr  <= tileNr + 16'd1;
          if (lastCol) begin
            xBase <= '0;
            yBase <= yBase + CW'(TILE_LINES);
          end else begin
            xBase <= xBase + CW'(tileW);
          end
        end else begin
          lineIdx <= lineIdx + 7'd1;
        end
      end
    end
  end
endmodule

// File: rtl/tile_scan_agen.sv
module tile_scan_agen
  import tile_scan_pkg::*;
#(
  parameter int XRES        = 640,
  parameter int YRES        = 480,
  parameter int CHUNK_BYTES = 16384,
  parameter int ADDR_W      = 32,
  localparam int LEN_W      = $clog2((CHUNK_BYTES > TILE_ROW_BYTES) ? CHUNK_BYTES : TILE_ROW_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [31:0]       regWrData,
  input  logic              frameStart,
  output logic              memReq,
  output logic              memIsDesc,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W-1:0]  memLen,
  output logic [31:0]       memDstOff,
  input  logic              memGnt,
  input  logic              memRdValid,
  input  logic [15:0]       memRdData,
  output logic              busy
);
  ctlStrobe_t  strb;
  logic [1:0]  depthCode;
  logic        linearMode, startOk, tileDone, frameDone;
  logic [22:0] tableBits;

  tile_scan_regs regs_i (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrSel(regWrSel), .wrData(regWrData),
    .depthCode(depthCode), .linearMode(linearMode), .tableBits(tableBits),
    .startOk(startOk)
  );

  tile_scan_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .startOk(startOk),
    .memGnt(memGnt), .memRdValid(memRdValid), .tileDone(tileDone),
    .frameDone(frameDone), .strb(strb), .memReq(memReq),
    .memIsDesc(memIsDesc), .busy(busy)
  );

  tile_scan_datapath #(
    .XRES(XRES), .YRES(YRES), .CHUNK_BYTES(CHUNK_BYTES),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgDepth(depthCode),
    .cfgLinear(linearMode), .cfgTable(tableBits), .rdData(memRdData),
    .reqAddr(memAddr), .reqLen(memLen), .reqDst(memDstOff),
    .tileDone(tileDone), .frameDone(frameDone)
  );
endmodule

// File: rtl/tile_scan_agen_chk.sv
module tile_scan_agen_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              memReq,
  input logic              memIsDesc,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LEN_W-1:0]  memLen,
  input logic [31:0]       memDstOff,
  input logic              memGnt,
  input logic              busy
);
  // R8: pending request held until granted (unless restarted)
  a_r8_hold_until_grant: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt && !frameStart |=> memReq && $stable(memAddr) &&
      $stable(memLen) && $stable(memDstOff) && $stable(memIsDesc));

  // R9: requests only during a walk
  a_r9_req_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R2: a walk begins only from a frame-start pulse
  a_r2_rise_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(frameStart));

  // R9: a walk ends on a grant (or on a start that is refused)
  a_r9_fall_on_grant: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(memGnt) || $past(frameStart));

  // R3: descriptor fetch shape
  a_r3_desc_shape: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memIsDesc |-> memLen == LEN_W'(2) && !memAddr[0] && memDstOff == 32'd0);

  // R5: data requests never empty
  a_r5_len_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memIsDesc |-> memLen != '0);
endmodule

bind tile_scan_agen tile_scan_agen_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/tile_scan_agen_tb_top.sv
`timescale 1ns/1ps
module tile_scan_agen_tb_top;
  localparam int XR = 200;
  localparam int YR = 300;
  localparam int CH = 4096;
  localparam int LW = 13;
  localparam int MAXE = 2048;
  localparam logic [31:0] TBL = 32'h0001_2200;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regWrSel = 0, frameStart = 0;
  logic [31:0] regWrData = 0;
  logic memReq, memIsDesc, busy;
  logic [31:0] memAddr, memDstOff;
  logic [LW-1:0] memLen;
  logic memGnt, memRdValid;
  logic [15:0] memRdData;

  always #2.5 clk = ~clk;

  tile_scan_agen #(.XRES(XR), .YRES(YR), .CHUNK_BYTES(CH), .ADDR_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .frameStart(frameStart), .memReq(memReq),
    .memIsDesc(memIsDesc), .memAddr(memAddr), .memLen(memLen),
    .memDstOff(memDstOff), .memGnt(memGnt), .memRdValid(memRdValid),
    .memRdData(memRdData), .busy(busy)
  );

  int nChk = 0, nBad = 0, cyc = 0, lastGrantCyc = 0;
  bit logD[MAXE]; int logA[MAXE], logL[MAXE], logO[MAXE]; int logN = 0;
  bit expD[MAXE]; int expA[MAXE], expL[MAXE], expO[MAXE]; int expN = 0;
  bit holdGrant = 0; int stabBad = 0;

  always @(posedge clk) cyc++;

  function automatic logic [15:0] descFn(input logic [31:0] a);
    return a[16:1] + 16'h0100;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: grant after 0..2 cycles, descriptor data one cycle after grant
  initial begin : responder
    int waitCnt = 0, grantN = 0, pendA = 0, pendL = 0;
    bit pendValid = 0, respDue = 0;
    logic [31:0] respAddr = 0;
    memGnt = 0; memRdValid = 0; memRdData = 0;
    forever begin
      @(negedge clk);
      memGnt = 0; memRdValid = 0;
      if (respDue) begin
        memRdValid = 1; memRdData = descFn(respAddr); respDue = 0;
      end
      if (holdGrant) pendValid = 0;
      else if (rstN && memReq) begin
        if (!pendValid) begin pendValid = 1; pendA = memAddr; pendL = int'(memLen); end
        if (waitCnt == 0) begin
          if (pendA != memAddr || pendL != int'(memLen)) stabBad++;
          if (logN < MAXE) begin
            logD[logN] = memIsDesc; logA[logN] = memAddr;
            logL[logN] = int'(memLen); logO[logN] = memDstOff;
          end
          logN++;
          memGnt = 1; lastGrantCyc = cyc;
          if (memIsDesc) begin respDue = 1; respAddr = memAddr; end
          grantN++; waitCnt = grantN % 3; pendValid = 0;
        end else waitCnt--;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nBad++; nChk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  task automatic push(input bit d, input int a, input int l, input int o);
    expD[expN] = d; expA[expN] = a; expL[expN] = l; expO[expN] = o; expN++;
  endtask

  task automatic buildTiled(input int d);
    int n = 0, tw = 512 >> d;
    expN = 0;
    for (int yb = 0; yb < YR; yb += 128)
      for (int xb = 0; xb < XR; xb += tw) begin
        int base, lines, pix;
        push(1, TBL + 2 * n, 2, 0);
        base = int'(descFn(TBL + 2 * n)) << 16;
        lines = (YR - yb < 128) ? YR - yb : 128;
        pix = (XR - xb < tw) ? XR - xb : tw;
        for (int y = 0; y < lines; y++)
          push(0, base + 512 * y, pix << d, ((yb + y) * XR + xb) << d);
        n++;
      end
  endtask

  task automatic buildLinear(input int d);
    int n = 0, w = 0, total = (XR * YR) << d;
    expN = 0;
    while (w < total) begin
      int base, off = 0;
      push(1, TBL + 2 * n, 2, 0);
      base = int'(descFn(TBL + 2 * n)) << 16;
      while (off < 65536 && w < total) begin
        int len = (total - w < CH) ? total - w : CH;
        push(0, base + off, len, w);
        w += len; off += CH;
      end
      n++;
    end
  endtask

  task automatic writeReg(input bit sel, input logic [31:0] v);
    @(negedge clk); regWrEn = 1; regWrSel = sel; regWrData = v;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic configure(input int d, input bit lin);
    writeReg(0, 32'(d) << 13);
    writeReg(1, {TBL[31:9], 7'b0, lin, 1'b1});
  endtask

  task automatic pulseStart();
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 50000) begin @(negedge clk); n++; end
    chk(!busy, req, "walk finishes", busy, 0);
    chk(cyc == lastGrantCyc + 1, "R9", "busy falls one cycle after last grant",
        cyc - lastGrantCyc, 1);
  endtask

  task automatic compareLog(input string req);
    int bad = 0;
    chk(logN == expN, req, "request count", logN, expN);
    for (int i = 0; i < expN && i < logN; i++)
      if (logD[i] != expD[i] || logA[i] != expA[i] || logL[i] != expL[i] || logO[i] != expO[i]) begin
        if (bad < 4) $display("FAIL %s entry %0d: actual=%0d/%0h/%0d/%0h expected=%0d/%0h/%0d/%0h",
          req, i, logD[i], logA[i], logL[i], logO[i], expD[i], expA[i], expL[i], expO[i]);
        bad++;
      end
    nChk++; if (bad != 0) nBad++;
    chk(stabBad == 0, "R8", "request held until grant", stabBad, 0);
  endtask

  task automatic runFrame(input string req);
    logN = 0; stabBad = 0;
    pulseStart();
    chk(busy == 1, "R9", "busy one cycle after start", busy, 1);
    waitIdle(req);
    compareLog(req);
  endtask

  task automatic testReset();
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(memReq == 0, "R1", "memReq after reset", memReq, 0);
  endtask

  task automatic testDisabled();
    writeReg(1, {TBL[31:9], 9'b0});          // R2: DMA enable bit 0 clear
    logN = 0; pulseStart(); repeat (10) @(negedge clk);
    chk(busy == 0 && logN == 0, "R2", "no walk with DMA off", logN, 0);
    writeReg(1, 32'h0000_0001);              // R2: zero table base
    pulseStart(); repeat (10) @(negedge clk);
    chk(busy == 0 && logN == 0, "R2", "no walk with zero base", logN, 0);
  endtask

  task automatic testTiled(input int d, input string req);
    configure(d, 0); buildTiled(d); runFrame(req);
  endtask

  task automatic testLinear(input int d);
    configure(d, 1); buildLinear(d); runFrame("R7");
  endtask

  task automatic testRestart();
    configure(0, 0); buildTiled(0);
    logN = 0; pulseStart();
    wait (logN >= 40);
    @(negedge clk); holdGrant = 1;
    repeat (3) @(negedge clk);
    logN = 0; stabBad = 0;
    frameStart = 1; @(negedge clk); frameStart = 0; holdGrant = 0;
    waitIdle("R10");
    compareLog("R10");
  endtask

  task automatic testSnapshot();
    configure(0, 0); buildTiled(0);
    logN = 0; stabBad = 0;
    pulseStart();
    repeat (20) @(negedge clk);
    configure(2, 1);                         // R11: mid-walk change
    waitIdle("R11");
    compareLog("R11");
    buildLinear(2); runFrame("R11");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testDisabled();
    testTiled(0, "R3");
    testTiled(1, "R5");
    testTiled(2, "R6");
    testTiled(3, "R4");
    testLinear(0);
    testLinear(2);
    testRestart();
    testSnapshot();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule